// File: doc/BRIEF.md
# Exception Priority and Vector Selection Unit

This unit sits beside the control path of a small processor core and decides which of seven pending exception sources is taken next. Every cycle it looks at the raw request lines, removes the two interrupt sources that the current status word masks, and picks the most urgent survivor by a fixed ranking. For the winner it returns a code, the privileged mode to enter, and the handler address.

The result is registered. It is presented together with a take strobe one clock after the sampling edge, and only if the pipeline signalled that it could accept a redirect. The unit also returns the interrupt mask bits that the core must load when it enters the handler. Between takes, the code, mode, vector and mask outputs keep the last taken values, so the core can read them at its own pace.

Top module: `exc_vector_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the outputs become: `take_o`=0, `exc_code_o`=0, `mode_o`=5'b10011, `vector_o`=VEC_BASE, and both new-mask outputs 1.
- R2: Request bits are reset=0, undefined=1, software call=2, prefetch abort=3, data abort=4, interrupt=5, fast interrupt=6, and `exc_code_o` carries the winner's bit index. The ranking from most to least urgent is reset, data abort, fast interrupt, interrupt, prefetch abort, then undefined and software call.
- R3: Undefined and software call share the lowest rank. If both are ever raised together, undefined wins.
- R4: `vector_o` equals VEC_BASE plus an offset: 0x00 reset, 0x04 undefined, 0x08 software call, 0x0C prefetch abort, 0x10 data abort, 0x18 interrupt, 0x1C fast interrupt.
- R5: `mode_o` is 10011 (supervisor) for reset and software call, 11011 for undefined, 10111 for either abort, 10010 for interrupt and 10001 for fast interrupt. A take never reports user (10000) or system (11111).
- R6: The interrupt request has no effect while `irq_mask_i` is 1, and the fast interrupt request has no effect while `fiq_mask_i` is 1. The other five sources are never masked.
- R7: On a take, `new_irq_mask_o` is 1. `new_fiq_mask_o` is 1 for reset or fast interrupt; otherwise it copies the sampled `fiq_mask_i`.
- R8: `take_o` rises one cycle after an edge at which `pipe_ready_i` was 1 and an unmasked request was pending. It never rises after an edge at which `pipe_ready_i` was 0.
- R9: `take_o` is high for exactly one cycle. The cycle after a take always has `take_o` low, even if requests are held.
- R10: While `take_o` is low, the code, mode, vector and new-mask outputs hold their last values.
- R11: The offset 0x14 is never produced as a vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_req_i | input | 7 | Pending request lines, bit map as in R2 |
| irq_mask_i | input | 1 | Interrupt mask bit from current status word |
| fiq_mask_i | input | 1 | Fast interrupt mask bit from current status word |
| pipe_ready_i | input | 1 | Pipeline can accept a redirect this cycle |
| take_o | output | 1 | One-cycle strobe: exception taken |
| exc_code_o | output | 3 | Index of the taken source |
| mode_o | output | 5 | Mode encoding to enter |
| vector_o | output | 32 | Handler address |
| new_irq_mask_o | output | 1 | Interrupt mask value to load on entry |
| new_fiq_mask_o | output | 1 | Fast interrupt mask value to load on entry |

## Verification
Arbitration and masking can act in the same cycle. A masked fast interrupt raised together with an interrupt and a prefetch abort must let the lower-ranked unmasked source through, not suppress the take. The bench provokes this with directed mask and request combinations and with thousands of random cycles. A behavioural model that walks an explicit ranking list predicts the take, code, mode, vector and masks, and compares them every clock. The one-cycle strobe window also meets held requests and a low ready signal in the same cycle, and the model judges this by its own record of the previous take.

// File: rtl/exc_vec_pkg.sv
package exc_vec_pkg;
  localparam int NUM_SRC = 7;
  localparam int CODE_W  = 3;
  localparam int MODE_W  = 5;

  typedef enum logic [CODE_W-1:0] {
    EXC_RESET = 3'd0,
    EXC_UNDEF = 3'd1,
    EXC_SWI   = 3'd2,
    EXC_PABT  = 3'd3,
    EXC_DABT  = 3'd4,
    EXC_IRQ   = 3'd5,
    EXC_FIQ   = 3'd6
  } exc_code_e;

  localparam logic [MODE_W-1:0] MODE_USR = 5'b10000;
  localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;
  localparam logic [MODE_W-1:0] MODE_SYS = 5'b11111;

  // rank 0 is the most urgent; undefined beats software call on a tie
  function automatic int rank_of(input int src);
    case (src)
      0:       rank_of = 0;
      4:       rank_of = 1;
      6:       rank_of = 2;
      5:       rank_of = 3;
      3:       rank_of = 4;
      1:       rank_of = 5;
      default: rank_of = 6;
    endcase
  endfunction

  // word slot of the handler; slot 5 is skipped
  function automatic logic [2:0] slot_of(input logic [CODE_W-1:0] code);
    slot_of = (code < 3'd5) ? code : code + 3'd1;
  endfunction
endpackage

// File: rtl/exc_req_filter.sv
module exc_req_filter
  import exc_vec_pkg::*;
#(
  parameter int N = NUM_SRC
) (
  input  logic [N-1:0] req_i,
  input  logic         irq_mask_i,
  input  logic         fiq_mask_i,
  output logic [N-1:0] eff_o
);
  for (genvar g = 0; g < N; g++) begin : g_src
    if (g == int'(EXC_IRQ)) begin : g_irq
      assign eff_o[g] = req_i[g] & ~irq_mask_i;
    end else if (g == int'(EXC_FIQ)) begin : g_fiq
      assign eff_o[g] = req_i[g] & ~fiq_mask_i;
    end else begin : g_plain
      assign eff_o[g] = req_i[g];
    end
  end
endmodule

// File: rtl/exc_prio_sel.sv
module exc_prio_sel
  import exc_vec_pkg::*;
#(
  parameter int N = NUM_SRC
) (
  input  logic [N-1:0]      eff_i,
  output logic              valid_o,
  output logic [CODE_W-1:0] code_o
);
  logic [N-1:0] win;

  for (genvar g = 0; g < N; g++) begin : g_win
    logic [N-1:0] beats;
    for (genvar h = 0; h < N; h++) begin : g_cmp
      if (rank_of(h) < rank_of(g)) begin : g_hi
        assign beats[h] = eff_i[h];
      end else begin : g_lo
        assign beats[h] = 1'b0;
      end
    end
    assign win[g] = eff_i[g] & ~(|beats);
  end

  always_comb begin
    code_o = '0;
    for (int i = 0; i < N; i++) begin
      if (win[i]) code_o = code_o | CODE_W'(i);
    end
  end

  assign valid_o = |eff_i;

  always_comb begin
    assert ($onehot0(win)) else $error("p_win_onehot_r2");
  end
endmodule

// File: rtl/exc_vec_map.sv
module exc_vec_map
  import exc_vec_pkg::*;
#(
  parameter int                ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] VEC_BASE = '0
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [ADDR_W-1:0] vector_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              set_fiq_mask_o
);
  localparam int PAD_W = ADDR_W - 5;

  logic [2:0] slot;
  assign slot     = slot_of(code_i);
  assign vector_o = VEC_BASE + {{PAD_W{1'b0}}, slot, 2'b00};

  always_comb begin
    case (exc_code_e'(code_i))
      EXC_RESET, EXC_SWI:  mode_o = MODE_SVC;
      EXC_UNDEF:           mode_o = MODE_UND;
      EXC_PABT, EXC_DABT:  mode_o = MODE_ABT;
      EXC_IRQ:             mode_o = MODE_IRQ;
      EXC_FIQ:             mode_o = MODE_FIQ;
      default:             mode_o = MODE_SVC;
    endcase
  end

  assign set_fiq_mask_o = (code_i == EXC_RESET) || (code_i == EXC_FIQ);
endmodule

// File: rtl/exc_vector_unit.sv
module exc_vector_unit
  import exc_vec_pkg::*;
#(
  parameter int                ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] VEC_BASE = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [6:0]        exc_req_i,
  input  logic              irq_mask_i,
  input  logic              fiq_mask_i,
  input  logic              pipe_ready_i,
  output logic              take_o,
  output logic [2:0]        exc_code_o,
  output logic [4:0]        mode_o,
  output logic [ADDR_W-1:0] vector_o,
  output logic              new_irq_mask_o,
  output logic              new_fiq_mask_o
);
  logic [NUM_SRC-1:0] eff;
  logic               any_pend;
  logic [CODE_W-1:0]  win_code;
  logic [ADDR_W-1:0]  win_vec;
  logic [MODE_W-1:0]  win_mode;
  logic               win_set_f;
  logic               accept;

  exc_req_filter #(.N(NUM_SRC)) u_filter (
    .req_i      (exc_req_i),
    .irq_mask_i (irq_mask_i),
    .fiq_mask_i (fiq_mask_i),
    .eff_o      (eff)
  );

  exc_prio_sel #(.N(NUM_SRC)) u_sel (
    .eff_i   (eff),
    .valid_o (any_pend),
    .code_o  (win_code)
  );

  exc_vec_map #(.ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE)) u_map (
    .code_i         (win_code),
    .vector_o       (win_vec),
    .mode_o         (win_mode),
    .set_fiq_mask_o (win_set_f)
  );

  // one idle cycle follows every take
  assign accept = any_pend & pipe_ready_i & ~take_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      take_o         <= 1'b0;
      exc_code_o     <= EXC_RESET;
      mode_o         <= MODE_SVC;
      vector_o       <= VEC_BASE;
      new_irq_mask_o <= 1'b1;
      new_fiq_mask_o <= 1'b1;
    end else begin
      take_o <= accept;
      if (accept) begin
        exc_code_o     <= win_code;
        mode_o         <= win_mode;
        vector_o       <= win_vec;
        new_irq_mask_o <= 1'b1;
        new_fiq_mask_o <= win_set_f | fiq_mask_i;
      end
    end
  end

  p_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    take_o |=> !take_o);
  p_ready_r8: assert property (@(posedge clk) disable iff (rst)
    take_o |-> $past(pipe_ready_i));
  p_irq_masked_r6: assert property (@(posedge clk) disable iff (rst)
    (take_o && exc_code_o == EXC_IRQ) |-> !$past(irq_mask_i));
  p_fiq_masked_r6: assert property (@(posedge clk) disable iff (rst)
    (take_o && exc_code_o == EXC_FIQ) |-> !$past(fiq_mask_i));
  p_no_gap_vec_r11: assert property (@(posedge clk) disable iff (rst)
    take_o |-> ((vector_o - VEC_BASE) != ADDR_W'(20)));
  p_priv_mode_r5: assert property (@(posedge clk) disable iff (rst)
    take_o |-> (mode_o != MODE_USR && mode_o != MODE_SYS));
  p_imask_set_r7: assert property (@(posedge clk) disable iff (rst)
    take_o |-> new_irq_mask_o);
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !take_o |-> ($stable(vector_o) && $stable(mode_o) && $stable(exc_code_o)));
endmodule

// File: tb/exc_vector_unit_bench.sv
module exc_vector_unit_bench;
  localparam logic [31:0] BASE = 32'h0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [6:0]  req = '0;
  logic        mi = 1'b0, mf = 1'b0, rdy = 1'b0;
  logic        take;
  logic [2:0]  code;
  logic [4:0]  mode;
  logic [31:0] vec;
  logic        nmi, nmf;

  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  exc_vector_unit #(.ADDR_W(32), .VEC_BASE(BASE)) u_exc_vector_unit (
    .clk(clk), .rst(rst), .exc_req_i(req), .irq_mask_i(mi), .fiq_mask_i(mf),
    .pipe_ready_i(rdy), .take_o(take), .exc_code_o(code), .mode_o(mode),
    .vector_o(vec), .new_irq_mask_o(nmi), .new_fiq_mask_o(nmf)
  );

  // behavioural reference
  int          order [7] = '{0, 4, 6, 5, 3, 1, 2};
  logic        e_take;
  logic [2:0]  e_code;
  logic [4:0]  e_mode;
  logic [31:0] e_vec;
  logic        e_nmi, e_nmf;

  function automatic logic [4:0] ref_mode(int s);
    case (s)
      0, 2: return 5'b10011;
      1:    return 5'b11011;
      3, 4: return 5'b10111;
      5:    return 5'b10010;
      default: return 5'b10001;
    endcase
  endfunction

  function automatic logic [31:0] ref_off(int s);
    case (s)
      0: return 32'h00; 1: return 32'h04; 2: return 32'h08; 3: return 32'h0C;
      4: return 32'h10; 5: return 32'h18; default: return 32'h1C;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      e_take <= 1'b0; e_code <= 3'd0; e_mode <= 5'b10011; e_vec <= BASE;
      e_nmi <= 1'b1; e_nmf <= 1'b1;
    end else begin
      int w;
      w = -1;
      for (int k = 6; k >= 0; k--) begin
        int s;
        s = order[k];
        if (req[s] && !(s == 5 && mi) && !(s == 6 && mf)) w = s;
      end
      if (rdy && !e_take && w >= 0) begin
        e_take <= 1'b1; e_code <= 3'(w); e_mode <= ref_mode(w);
        e_vec <= BASE + ref_off(w); e_nmi <= 1'b1;
        e_nmf <= (w == 0 || w == 6) ? 1'b1 : mf;
      end else begin
        e_take <= 1'b0;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk("R8 R9 R6 take", 32'(take), 32'(e_take));
    if (e_take) begin
      chk("R2 R3 code", 32'(code), 32'(e_code));
      chk("R5 mode", 32'(mode), 32'(e_mode));
      chk("R4 vector", vec, e_vec);
      chk("R7 masks", {30'd0, nmi, nmf}, {30'd0, e_nmi, e_nmf});
      n_run++;
      if (vec - BASE == 32'h14) begin
        n_fail++;
        $display("FAIL R11 actual=%0h expected=not 14", vec);
      end
    end else begin
      chk("R10 hold vector", vec, e_vec);
      chk("R10 hold code", 32'(code), 32'(e_code));
      chk("R10 hold mode", 32'(mode), 32'(e_mode));
    end
  endtask

  task automatic cyc(input logic [6:0] r, input logic i_m, input logic f_m, input logic rd);
    @(negedge clk);
    compare();
    req = r; mi = i_m; mf = f_m; rdy = rd;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 take", 32'(take), 32'd0);
    chk("R1 code", 32'(code), 32'd0);
    chk("R1 mode", 32'(mode), 32'h13);
    chk("R1 vector", vec, BASE);
    chk("R1 masks", {30'd0, nmi, nmf}, 32'd3);
    rst = 1'b0;
    // each source alone (R2 R4 R5)
    for (int s = 0; s < 7; s++) begin
      cyc(7'(1 << s), 0, 0, 1);
      cyc(0, 0, 0, 1);
      cyc(0, 0, 0, 1);
    end
    // ranking: drop the winner each time (R2)
    begin
      logic [6:0] p;
      p = 7'h7F;
      for (int k = 0; k < 7; k++) begin
        cyc(p, 0, 0, 1);
        cyc(0, 0, 0, 1);
        cyc(0, 0, 0, 1);
        p[order[k]] = 1'b0;
      end
    end
    // tie R3
    cyc(7'b0000110, 0, 0, 1); cyc(0, 0, 0, 1); cyc(0, 0, 0, 1);
    // masking R6 with mixed sources, R7 fiq mask copy
    cyc(7'b1000000, 0, 1, 1); cyc(0, 0, 0, 1); cyc(0, 0, 0, 1);
    cyc(7'b0100000, 1, 0, 1); cyc(0, 0, 0, 1); cyc(0, 0, 0, 1);
    cyc(7'b1101000, 0, 1, 1); cyc(0, 0, 0, 1); cyc(0, 0, 0, 1);
    cyc(7'b1101000, 1, 1, 1); cyc(0, 0, 0, 1); cyc(0, 0, 0, 1);
    cyc(7'b0011001, 1, 1, 1); cyc(0, 0, 0, 1); cyc(0, 0, 0, 1);
    // ready low R8, then held request R9
    cyc(7'b0010000, 0, 0, 0); cyc(7'b0010000, 0, 0, 0); cyc(7'b0010000, 0, 0, 1);
    for (int k = 0; k < 6; k++) cyc(7'b0100000, 0, 0, 1);
    cyc(0, 0, 0, 1); cyc(0, 0, 0, 1);
    // random traffic
    for (int k = 0; k < 4000; k++) begin
      logic [6:0] r;
      r = 7'($urandom) & 7'($urandom);
      cyc(r, 1'($urandom), 1'($urandom), ($urandom % 4) != 0);
    end
    cyc(0, 0, 0, 0); cyc(0, 0, 0, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule